// File: doc/BRIEF.md
# Soft Reset Control Register Bank

This block is a small bank of bus-addressed control registers whose flops drive a flat vector of soft reset lines into neighbouring peripherals. Software writes a register to put one or more peripherals into reset and writes it again to release them. A set bit means that line's reset is active. Each register slot owns a contiguous group of lines, and the slots sit one 32-bit word apart in the byte address space.

A build-time parameter picks one of two write styles. In the masked style, each register carries 16 lines in its low half. The high half of every write word acts as a per-bit enable for the low half, so a single write can set or clear any chosen lines without touching the others. No read-modify-write sequence and no software lock is needed. In the plain style, each register carries 32 lines and a write replaces the whole word. Reads are captured into a read-data register on the clock edge where the read strobe is sampled.

Top module: `srst_bank`

## Requirements
- R1: While and after hardware reset, with the default parameters, every reset output is 0 and the read data is 0.
- R2: Masked style: a write whose word has bit k and bit k+16 set drives the addressed register's bit k to 1. Every other bit of every register keeps its value.
- R3: Masked style: a write whose word has bit k+16 set and bit k clear drives the addressed register's bit k to 0. All other bits keep their values.
- R4: Masked style: a low-half write bit whose enable bit (its position plus 16) is 0 is ignored. A write with bits 31:16 all 0 changes no output.
- R5: Plain style (32 lines per register): a write replaces all 32 bits of the addressed register with the write word.
- R6: Register i answers at byte address 4*i, and address bits 1:0 are ignored. Line N is bit N mod L of register N div L, where L is 16 (masked) or 32 (plain), and it appears at rst_out[N].
- R7: A write to a word index of NUM_REGS or above changes no output. A read from such an address returns 0.
- R8: A read strobe loads rdata on the following clock edge. In masked style, rdata bits 31:16 are 0. Without a read strobe, rdata holds its value.
- R9: When a read and a write target the same register in the same cycle, rdata returns the value from before the write, and the write still takes effect on that edge.
- R10: A write changes rst_out on the clock edge that samples the write strobe. With no write strobe, rst_out holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| wdata | input | 32 | Write word |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 32 | Registered read data |
| rst_out | output | NUM_REGS*L | Soft reset lines, 1 = asserted |

## Verification
A read and a write can land on the same register in the same cycle. The read capture must see the old contents while the register update lands on that same edge. The bench provokes this with a directed case that reads a register while clearing bits in it. The random phase also raises both strobes together with independent probability on overlapping addresses. The judgement compares rdata against the bench model's value from before the write, and rst_out against the model after the write, on the cycle that follows.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  // lines held by one register for a given write style
  function automatic int unsigned lines_per_reg(input int unsigned masked);
    return (masked != 0) ? HALF_W : WORD_W;
  endfunction

  // masked update: enabled bits take the new value, others keep the old one
  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] cur,
    input logic [WORD_W-1:0] wd
  );
    logic [HALF_W-1:0] en;
    en = wd[WORD_W-1:HALF_W];
    return (cur & ~en) | (wd[HALF_W-1:0] & en);
  endfunction
endpackage

// File: rtl/srst_addr_dec.sv
module srst_addr_dec #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  logic [31:0] word_w;

  always_comb begin
    word_w   = 32'(addr[ADDR_W-1:2]);
    in_range = (word_w < NUM_REGS);
    idx      = IDX_W'(word_w);
  end
endmodule

// File: rtl/srst_reg_slot.sv
module srst_reg_slot
  import srst_pkg::*;
#(
  parameter int unsigned      MASK_MODE = 1,
  parameter int unsigned      LPR       = 16,
  parameter logic [LPR-1:0]   DEFAULT_V = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [LPR-1:0]    q
);
  logic [LPR-1:0] q_nxt;
  logic [LPR-1:0] upd;

  generate
    if (MASK_MODE != 0) begin : g_masked
      always_comb upd = LPR'(masked_merge(HALF_W'(q), wdata));
    end else begin : g_plain
      always_comb upd = wdata[LPR-1:0];
    end
  endgenerate

  // explicit clock enable: hold unless this slot is written
  always_comb begin
    q_nxt = q;
    if (wr_sel) q_nxt = upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= DEFAULT_V;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/srst_read_mux.sv
module srst_read_mux
  import srst_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned LPR      = 16,
  parameter int unsigned IDX_W    = 2,
  localparam int unsigned NLINES  = NUM_REGS * LPR
) (
  input  logic [NLINES-1:0] lines,
  input  logic [IDX_W-1:0]  idx,
  input  logic              in_range,
  output logic [WORD_W-1:0] rd_word
);
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (in_range && (idx == IDX_W'(i)))
        rd_word[LPR-1:0] = lines[i*LPR +: LPR];
    end
  end
endmodule

// File: rtl/srst_bank.sv
module srst_bank
  import srst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned MASK_MODE = 1,
  parameter logic [NUM_REGS*((MASK_MODE != 0) ? 16 : 32)-1:0] RST_DEFAULT = '0
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [ADDR_W-1:0]                           addr,
  input  logic [31:0]                                 wdata,
  input  logic                                        wr_en,
  input  logic                                        rd_en,
  output logic [31:0]                                 rdata,
  output logic [NUM_REGS*((MASK_MODE != 0) ? 16 : 32)-1:0] rst_out
);
  localparam int unsigned LPR    = lines_per_reg(MASK_MODE);
  localparam int unsigned NLINES = NUM_REGS * LPR;
  localparam int unsigned IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rdata_nxt;
  logic [NLINES-1:0] lines;

  srst_addr_dec #(
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_dec (
    .addr    (addr),
    .idx     (idx),
    .in_range(in_range)
  );

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      logic sel;
      always_comb sel = wr_en && in_range && (idx == IDX_W'(i));
      srst_reg_slot #(
        .MASK_MODE(MASK_MODE),
        .LPR      (LPR),
        .DEFAULT_V(RST_DEFAULT[i*LPR +: LPR])
      ) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_sel(sel),
        .wdata (wdata),
        .q     (lines[i*LPR +: LPR])
      );
    end
  endgenerate

  srst_read_mux #(
    .NUM_REGS(NUM_REGS),
    .LPR     (LPR),
    .IDX_W   (IDX_W)
  ) u_rmux (
    .lines   (lines),
    .idx     (idx),
    .in_range(in_range),
    .rd_word (rd_word)
  );

  // read capture sees pre-write contents (flop outputs)
  always_comb begin
    rdata_nxt = rdata;
    if (rd_en) rdata_nxt = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_nxt;
  end

  assign rst_out = lines;
endmodule

// File: rtl/srst_bank_chk.sv
module srst_bank_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned MASK_MODE = 1,
  localparam int unsigned NLINES   = NUM_REGS * ((MASK_MODE != 0) ? 16 : 32)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [31:0]       rdata,
  input logic [NLINES-1:0] rst_out
);
  logic [31:0] word_w;
  logic        oor;
  always_comb begin
    word_w = 32'(addr[ADDR_W-1:2]);
    oor    = (word_w >= NUM_REGS);
  end

  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rst_out));

  // R7
  oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && oor) |=> $stable(rst_out));

  // R7
  oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && oor) |=> (rdata == 32'h0));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  generate
    if (MASK_MODE != 0) begin : g_mask_chk
      // R8
      upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata[31:16] == 16'h0));

      // R4
      no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wdata[31:16] == 16'h0)) |=> $stable(rst_out));
    end
  endgenerate
endmodule

bind srst_bank srst_bank_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_REGS (NUM_REGS),
  .MASK_MODE(MASK_MODE)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .addr   (addr),
  .wdata  (wdata),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .rdata  (rdata),
  .rst_out(rst_out)
);

// File: tb/srst_bank_tb.sv
`timescale 1ns/1ps
module srst_bank_tb;
  logic        clk;
  logic        rst_n;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic        wr_en;
  logic        rd_en;
  logic [31:0] rdata_m, rdata_p;
  logic [63:0]  out_m;
  logic [127:0] out_p;

  int n_chk;
  int n_fail;

  // bench model
  logic [15:0] m_msk [4];
  logic [31:0] m_pln [4];
  logic [31:0] rd_m, rd_p;

  srst_bank #(.MASK_MODE(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata_m), .rst_out(out_m)
  );

  srst_bank #(.MASK_MODE(0)) u_dut_plain (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata_p), .rst_out(out_p)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] flat_m();
    logic [63:0] v;
    for (int i = 0; i < 4; i++) v[i*16 +: 16] = m_msk[i];
    return v;
  endfunction

  function automatic logic [127:0] flat_p();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = m_pln[i];
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, model updated at posedge, ready to sample at next negedge
  task automatic apply(input logic [7:0] a, input logic [31:0] d, input logic we, input logic re);
    int idx;
    addr = a; wdata = d; wr_en = we; rd_en = re;
    @(posedge clk);
    idx = int'(a[7:2]);
    if (re) begin
      rd_m = (idx < 4) ? {16'h0, m_msk[idx]} : 32'h0;
      rd_p = (idx < 4) ? m_pln[idx] : 32'h0;
    end
    if (we && idx < 4) begin
      m_msk[idx] = (m_msk[idx] & ~d[31:16]) | (d[15:0] & d[31:16]);
      m_pln[idx] = d;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    for (int i = 0; i < 4; i++) begin m_msk[i] = '0; m_pln[i] = '0; end
    rd_m = '0; rd_p = '0;
    addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", {64'h0, out_m}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {64'h0, out_m}, 128'h0);
    check("R1", out_p, 128'h0);
    check("R1", {96'h0, rdata_m}, 128'h0);

    // R2 assert line 5
    apply(8'h00, 32'h0020_0020, 1'b1, 1'b0);
    check("R2", {127'h0, out_m[5]}, 128'h1);
    check("R2", {64'h0, out_m}, {64'h0, flat_m()});

    // R6 register 1 at byte 4: line 20 = reg1 bit4
    apply(8'h04, 32'h0010_0010, 1'b1, 1'b0);
    check("R6", {127'h0, out_m[20]}, 128'h1);
    check("R6", {127'h0, out_p[36]}, 128'h1);

    // R3 deassert line 5
    apply(8'h00, 32'h0020_0000, 1'b1, 1'b0);
    check("R3", {127'h0, out_m[5]}, 128'h0);
    check("R3", {64'h0, out_m}, {64'h0, flat_m()});

    // R4 no enables: nothing changes
    apply(8'h00, 32'h0000_FFFF, 1'b1, 1'b0);
    check("R4", {112'h0, out_m[15:0]}, 128'h0);
    check("R4", {64'h0, out_m}, {64'h0, flat_m()});

    // R6 low address bits ignored: byte 7 hits reg1 bit0 -> line 16
    apply(8'h07, 32'h0001_0001, 1'b1, 1'b0);
    check("R6", {127'h0, out_m[16]}, 128'h1);

    // R7 out of range write and read
    apply(8'h40, 32'hFFFF_FFFF, 1'b1, 1'b1);
    check("R7", {64'h0, out_m}, {64'h0, flat_m()});
    check("R7", out_p, flat_p());
    check("R7", {96'h0, rdata_m}, 128'h0);

    // R8 readback, upper half zero
    apply(8'h04, 32'hFFFF_FFFF, 1'b0, 1'b1);
    check("R8", {96'h0, rdata_m}, 128'h0011);
    check("R8", {96'h0, rdata_p}, {96'h0, rd_p});
    // R8 hold without strobe
    apply(8'h00, 32'h0, 1'b0, 1'b0);
    check("R8", {96'h0, rdata_m}, 128'h0011);

    // R9 read and write same register same cycle
    apply(8'h04, 32'h0011_0000, 1'b1, 1'b1);
    check("R9", {96'h0, rdata_m}, 128'h0011);
    check("R9", {112'h0, out_m[31:16]}, 128'h0);

    // R5 plain replace
    apply(8'h08, 32'hA5A5_5A5A, 1'b1, 1'b0);
    check("R5", {96'h0, out_p[95:64]}, 128'hA5A5_5A5A);
    apply(8'h08, 32'h0000_0001, 1'b1, 1'b1);
    check("R9", {96'h0, rdata_p}, 128'hA5A5_5A5A);
    check("R5", {96'h0, out_p[95:64]}, 128'h1);

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [7:0]  ra;
      logic [31:0] rd;
      ra = 8'($urandom_range(0, 47));
      rd = $urandom();
      apply(ra, rd, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      check("R10", {64'h0, out_m}, {64'h0, flat_m()});
      check("R5", out_p, flat_p());
      check("R8", {96'h0, rdata_m}, {96'h0, rd_m});
      check("R8", {96'h0, rdata_p}, {96'h0, rd_p});
    end

    finish_run();
  end
endmodule